// File: doc/BRIEF.md
# Taken-Branch Destination Word Cache

This block is a small, fully associative store that sits next to the fetch stage. It is keyed by the address of a taken branch. Each entry keeps the instruction words found at that branch's destination, plus the sequential fetch address that follows them. When fetch presents a branch address that hits, the destination words and the continuation address come back on the next clock edge. The stream can therefore continue past a taken branch with no bubble and no access to any instruction cache. Without this store, a taken branch costs at least one bubble from the small first-level cache and several cycles from the larger one. It also means the first-level cache does not have to be built for single-cycle access.

Entries are written only when a taken branch has been resolved and its lookup missed. The words are supplied by the normal instruction path. A victim is chosen by a rotating pointer, unless the branch address is already held, in which case that entry is rewritten in place. A flush request clears every entry in one cycle.

Top module: `branch_dest_cache`

## Requirements
- R1: After reset, `hit` is 0 and `hit_words` and `hit_next_addr` are all zero.
- R2: A lookup (`lkp_valid`=1) of an address held in a valid entry gives, one clock edge later, `hit`=1 together with the stored words and next address. `hit_words` packs word k in bits [32k+31:32k].
- R3: Whenever `hit` is 0, `hit_words` and `hit_next_addr` are all zero. This includes a lookup of an address that is not held.
- R4: `hit` is 1 only in the cycle after a cycle in which `lkp_valid` was 1. Presenting an address with `lkp_valid`=0 gives no hit.
- R5: An allocation of an address not held goes to the entry under the rotating pointer, and the pointer then advances by one, wrapping after the last of the 16 entries. After 16 distinct allocations, the 17th evicts the first.
- R6: An allocation of an address that is already held rewrites that entry and does not advance the pointer. No address is ever held by two entries.
- R7: A lookup and an allocation of the same address in the same cycle return a miss. The allocation still completes, so a later lookup hits.
- R8: A flush clears all entries in one cycle. An allocation presented in the flush cycle is dropped.
- R9: A lookup presented in the same cycle as a flush returns a miss.
- R10: The tag compare covers every address bit. An address that differs from a held one in any single bit misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lkp_valid | input | 1 | Lookup request this cycle |
| lkp_addr | input | ADDR_W | Taken-branch address to look up |
| alloc_valid | input | 1 | Resolved taken branch that missed: write an entry |
| alloc_addr | input | ADDR_W | Branch address to store as tag |
| alloc_words | input | WORDS*WORD_W | Destination instruction words |
| alloc_next_addr | input | ADDR_W | Fetch address following the stored words |
| hit | output | 1 | Registered lookup hit |
| hit_words | output | WORDS*WORD_W | Destination words on hit, zero otherwise |
| hit_next_addr | output | ADDR_W | Continuation fetch address on hit, zero otherwise |

## Verification
On every cycle, the assertions check the following. A hit must follow a lookup that matched, and a miss must carry all-zero data. A same-address lookup and allocation, or any flush, must yield a miss, and a flush must leave no valid entry. No two entries may match one address. The pointer must step on a fresh allocation and hold on an in-place rewrite. Only the bench's scenarios can show which entry a given allocation actually evicted, that a rewritten entry returns its new words, and that single-bit address neighbours miss. These are seen as hits and misses across a full fill, a wrap, a rewrite and a flush.

// File: rtl/bdc_pkg.sv
package bdc_pkg;

  // What the write port does in a given cycle.
  typedef enum logic [1:0] {
    ACT_IDLE   = 2'd0,
    ACT_NEW    = 2'd1,   // fresh entry at the rotating pointer
    ACT_UPDATE = 2'd2,   // rewrite the entry already holding this tag
    ACT_DROP   = 2'd3    // request discarded because of a flush
  } alloc_act_e;

  function automatic alloc_act_e pick_action(input logic req,
                                             input logic fl,
                                             input logic present);
    if (!req)        return ACT_IDLE;
    else if (fl)     return ACT_DROP;
    else if (present) return ACT_UPDATE;
    else             return ACT_NEW;
  endfunction

endpackage

// File: rtl/bdc_tag_match.sv
module bdc_tag_match #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32
) (
  input  logic [ENTRIES*ADDR_W-1:0] tags,
  input  logic [ENTRIES-1:0]        valid,
  input  logic [ADDR_W-1:0]         addr,
  output logic [ENTRIES-1:0]        match
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign match[e] = valid[e] && (tags[e*ADDR_W +: ADDR_W] == addr);
  end

endmodule

// File: rtl/bdc_rr_ptr.sv
module bdc_rr_ptr #(
  parameter int ENTRIES = 16,
  localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  output logic [PTR_W-1:0] ptr
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      ptr <= '0;
    end else if (advance) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

endmodule

// File: rtl/bdc_entry_array.sv
module bdc_entry_array #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int PAY_W   = 160,
  localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear_all,
  input  logic                      wr_en,
  input  logic [PTR_W-1:0]          wr_idx,
  input  logic [ADDR_W-1:0]         wr_tag,
  input  logic [PAY_W-1:0]          wr_pay,
  output logic [ENTRIES-1:0]        valid,
  output logic [ENTRIES*ADDR_W-1:0] tags,
  output logic [ENTRIES*PAY_W-1:0]  pays
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == PTR_W'(e));

    always_ff @(posedge clk) begin
      if (!rst_n || clear_all) begin
        valid[e] <= 1'b0;
      end else if (sel) begin
        valid[e] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tags[e*ADDR_W +: ADDR_W] <= wr_tag;
        pays[e*PAY_W +: PAY_W]   <= wr_pay;
      end
    end
  end

endmodule

// File: rtl/bdc_onehot_mux.sv
module bdc_onehot_mux #(
  parameter int N = 16,
  parameter int W = 160
) (
  input  logic [N-1:0]   sel,
  input  logic [N*W-1:0] din,
  output logic [W-1:0]   dout
);

  always_comb begin
    dout = '0;
    for (int i = 0; i < N; i++) begin
      if (sel[i]) dout = dout | din[i*W +: W];
    end
  end

endmodule

// File: rtl/branch_dest_cache.sv
module branch_dest_cache #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int WORDS   = 4,
  parameter int WORD_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      lkp_valid,
  input  logic [ADDR_W-1:0]         lkp_addr,
  input  logic                      alloc_valid,
  input  logic [ADDR_W-1:0]         alloc_addr,
  input  logic [WORDS*WORD_W-1:0]   alloc_words,
  input  logic [ADDR_W-1:0]         alloc_next_addr,
  output logic                      hit,
  output logic [WORDS*WORD_W-1:0]   hit_words,
  output logic [ADDR_W-1:0]         hit_next_addr
);
  import bdc_pkg::*;

  localparam int LINE_W = WORDS * WORD_W;
  localparam int PAY_W  = LINE_W + ADDR_W;
  localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // Named internal events, also observed by the bound checker.
  logic [ENTRIES-1:0]        valid_vec;
  logic [ENTRIES*ADDR_W-1:0] tag_flat;
  logic [ENTRIES*PAY_W-1:0]  pay_flat;
  logic [ENTRIES-1:0]        lkp_match;
  logic [ENTRIES-1:0]        alloc_match;
  logic                      alloc_present;
  logic [PTR_W-1:0]          ptr;
  logic [PTR_W-1:0]          held_idx;
  logic [PTR_W-1:0]          wr_idx;
  logic                      wr_en;
  logic                      collide;
  logic                      lkp_hit_d;
  logic [PAY_W-1:0]          rd_pay;
  alloc_act_e                alloc_act;

  function automatic logic [PTR_W-1:0] encode_onehot(input logic [ENTRIES-1:0] v);
    logic [PTR_W-1:0] r;
    r = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (v[i]) r = r | PTR_W'(i);
    end
    return r;
  endfunction

  bdc_tag_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_lkp_match (
    .tags (tag_flat),
    .valid(valid_vec),
    .addr (lkp_addr),
    .match(lkp_match)
  );

  bdc_tag_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_alloc_match (
    .tags (tag_flat),
    .valid(valid_vec),
    .addr (alloc_addr),
    .match(alloc_match)
  );

  assign alloc_present = |alloc_match;
  assign held_idx      = encode_onehot(alloc_match);
  assign alloc_act     = pick_action(alloc_valid, flush, alloc_present);
  assign wr_en         = (alloc_act == ACT_NEW) || (alloc_act == ACT_UPDATE);
  assign wr_idx        = (alloc_act == ACT_UPDATE) ? held_idx : ptr;

  bdc_rr_ptr #(.ENTRIES(ENTRIES)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (flush),
    .advance(alloc_act == ACT_NEW),
    .ptr    (ptr)
  );

  bdc_entry_array #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .PAY_W(PAY_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_all(flush),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_tag   (alloc_addr),
    .wr_pay   ({alloc_words, alloc_next_addr}),
    .valid    (valid_vec),
    .tags     (tag_flat),
    .pays     (pay_flat)
  );

  bdc_onehot_mux #(.N(ENTRIES), .W(PAY_W)) u_rd_mux (
    .sel (lkp_match),
    .din (pay_flat),
    .dout(rd_pay)
  );

  assign collide   = lkp_valid && alloc_valid && (lkp_addr == alloc_addr);
  assign lkp_hit_d = lkp_valid && (|lkp_match) && !collide && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit           <= 1'b0;
      hit_words     <= '0;
      hit_next_addr <= '0;
    end else begin
      hit           <= lkp_hit_d;
      hit_words     <= lkp_hit_d ? rd_pay[PAY_W-1 -: LINE_W] : '0;
      hit_next_addr <= lkp_hit_d ? rd_pay[ADDR_W-1:0]        : '0;
    end
  end

endmodule

// File: rtl/bdc_checker.sv
module bdc_checker #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int LINE_W  = 128,
  localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 flush,
  input logic                 lkp_valid,
  input logic [ADDR_W-1:0]    lkp_addr,
  input logic                 alloc_valid,
  input logic [ADDR_W-1:0]    alloc_addr,
  input logic                 hit,
  input logic [LINE_W-1:0]    hit_words,
  input logic [ADDR_W-1:0]    hit_next_addr,
  input logic [ENTRIES-1:0]   lkp_match,
  input logic [ENTRIES-1:0]   valid_vec,
  input logic [PTR_W-1:0]     ptr,
  input bdc_pkg::alloc_act_e  alloc_act
);
  import bdc_pkg::*;

  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  AST_HIT_NEEDS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(lkp_valid)); // R4

  AST_HIT_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(|lkp_match)); // R2

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_words == '0 && hit_next_addr == '0)); // R3

  AST_COLLIDE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && alloc_valid && lkp_addr == alloc_addr) |=> !hit); // R7

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0)); // R8

  AST_FLUSH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hit); // R9

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lkp_match)); // R6

  AST_UPDATE_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_act == ACT_UPDATE) |=> $stable(ptr)); // R6

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_act == ACT_NEW) |=>
      (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1))); // R5

endmodule

bind branch_dest_cache bdc_checker #(
  .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LINE_W(WORDS*WORD_W)
) u_bdc_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush        (flush),
  .lkp_valid    (lkp_valid),
  .lkp_addr     (lkp_addr),
  .alloc_valid  (alloc_valid),
  .alloc_addr   (alloc_addr),
  .hit          (hit),
  .hit_words    (hit_words),
  .hit_next_addr(hit_next_addr),
  .lkp_match    (lkp_match),
  .valid_vec    (valid_vec),
  .ptr          (ptr),
  .alloc_act    (alloc_act)
);

// File: tb/branch_dest_cache_bench.sv
`timescale 1ns/1ps
module branch_dest_cache_bench;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         flush;
  logic         lkp_valid;
  logic [31:0]  lkp_addr;
  logic         alloc_valid;
  logic [31:0]  alloc_addr;
  logic [127:0] alloc_words;
  logic [31:0]  alloc_next_addr;
  logic         hit;
  logic [127:0] hit_words;
  logic [31:0]  hit_next_addr;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  branch_dest_cache u_branch_dest_cache (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lkp_valid(lkp_valid), .lkp_addr(lkp_addr),
    .alloc_valid(alloc_valid), .alloc_addr(alloc_addr),
    .alloc_words(alloc_words), .alloc_next_addr(alloc_next_addr),
    .hit(hit), .hit_words(hit_words), .hit_next_addr(hit_next_addr)
  );

  // Arithmetic models of addresses and stored content.
  function automatic logic [31:0] addr_of(input int i);
    return 32'h4000_0000 + 32'(i) * 32'h104;
  endfunction

  function automatic logic [127:0] words_of(input logic [31:0] a, input int s);
    return {a ^ 32'hA5A5_0000 ^ 32'(s), a + 32'(s) + 32'd1, ~a, a * 32'd3 + 32'(s)};
  endfunction

  function automatic logic [31:0] next_of(input logic [31:0] a, input int s);
    return a + 32'h10 + 32'(s) * 32'h100;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [159:0] act, input logic [159:0] exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_out(input bit eh, input logic [127:0] ew, input logic [31:0] en,
                           input string req);
    check(hit == eh, req, "hit", 160'(hit), 160'(eh));
    check(hit_words == ew && hit_next_addr == en, req, "data",
          {hit_words, hit_next_addr}, {ew, en});
  endtask

  task automatic lookup(input logic [31:0] a, input bit eh, input int s, input string req);
    @(negedge clk);
    lkp_valid = 1'b1; lkp_addr = a;
    @(negedge clk);
    lkp_valid = 1'b0;
    if (eh) check_out(1'b1, words_of(a, s), next_of(a, s), req);
    else    check_out(1'b0, '0, '0, req);
  endtask

  task automatic alloc(input logic [31:0] a, input int s);
    @(negedge clk);
    alloc_valid = 1'b1; alloc_addr = a;
    alloc_words = words_of(a, s); alloc_next_addr = next_of(a, s);
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  initial begin
    #(4.0 * 100000);
    if (!done) begin
      n_vec++; n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; lkp_valid = 1'b0; lkp_addr = '0;
    alloc_valid = 1'b0; alloc_addr = '0; alloc_words = '0; alloc_next_addr = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check_out(1'b0, '0, '0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_out(1'b0, '0, '0, "R1");

    // R3: empty cache misses with zero data
    for (int i = 0; i < 16; i++) lookup(addr_of(i), 1'b0, 0, "R3");

    // R2: fill all entries, each returns its own words
    for (int i = 0; i < 16; i++) alloc(addr_of(i), 0);
    for (int i = 0; i < 16; i++) lookup(addr_of(i), 1'b1, 0, "R2");

    // R4: address presented without lookup strobe
    @(negedge clk);
    lkp_addr = addr_of(3);
    @(negedge clk);
    check_out(1'b0, '0, '0, "R4");

    // R10: every single-bit neighbour of a held address misses
    for (int b = 0; b < 32; b++) lookup(addr_of(0) ^ (32'd1 << b), 1'b0, 0, "R10");

    // R6: rewrite a held tag in place; pointer stays at entry 0
    alloc(addr_of(5), 1);
    lookup(addr_of(5), 1'b1, 1, "R6");
    alloc(addr_of(16), 0);                 // evicts entry 0 (addr 0)
    lookup(addr_of(0),  1'b0, 0, "R6");
    lookup(addr_of(1),  1'b1, 0, "R6");
    lookup(addr_of(16), 1'b1, 0, "R6");
    lookup(addr_of(5),  1'b1, 1, "R6");

    // R5: rotation continues to entry 1 then 2
    alloc(addr_of(17), 0);
    lookup(addr_of(1),  1'b0, 0, "R5");
    lookup(addr_of(2),  1'b1, 0, "R5");
    lookup(addr_of(17), 1'b1, 0, "R5");

    // R7: same-cycle lookup and allocation of one address
    @(negedge clk);
    lkp_valid = 1'b1; lkp_addr = addr_of(20);
    alloc_valid = 1'b1; alloc_addr = addr_of(20);
    alloc_words = words_of(addr_of(20), 2); alloc_next_addr = next_of(addr_of(20), 2);
    @(negedge clk);
    lkp_valid = 1'b0; alloc_valid = 1'b0;
    check_out(1'b0, '0, '0, "R7");
    lookup(addr_of(20), 1'b1, 2, "R7");
    lookup(addr_of(2),  1'b0, 0, "R5");   // entry 2 was the victim

    // R9: lookup during flush misses
    @(negedge clk);
    flush = 1'b1; lkp_valid = 1'b1; lkp_addr = addr_of(16);
    @(negedge clk);
    flush = 1'b0; lkp_valid = 1'b0;
    check_out(1'b0, '0, '0, "R9");

    // R8: everything gone after flush
    for (int i = 3; i < 21; i++) lookup(addr_of(i), 1'b0, 0, "R8");

    // R8: allocation in a flush cycle is dropped
    @(negedge clk);
    flush = 1'b1; alloc_valid = 1'b1; alloc_addr = addr_of(30);
    alloc_words = words_of(addr_of(30), 0); alloc_next_addr = next_of(addr_of(30), 0);
    @(negedge clk);
    flush = 1'b0; alloc_valid = 1'b0;
    lookup(addr_of(30), 1'b0, 0, "R8");

    // R5: refill after flush, 17th allocation evicts the oldest
    for (int i = 40; i < 57; i++) alloc(addr_of(i), 3);
    lookup(addr_of(40), 1'b0, 0, "R5");
    for (int i = 41; i < 57; i++) lookup(addr_of(i), 1'b1, 3, "R5");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule